// File: doc/BRIEF.md
# Dual-Enable Mode-Decoded ALU

This block is a registered two-operand arithmetic logic unit. A master enable gates the whole unit. Two group enables pick which of three opcode tables is active. With only the first group enabled, a 3-bit opcode selects one of seven operations. With only the second group enabled, a 2-bit opcode selects one of three operations. With both groups enabled, the same 2-bit opcode selects one of four further operations. The opcode that the active table does not use is ignored.

Each table except the four-entry one has one reserved code. When that code is presented, the unit registers a zero result and raises an error output for that one cycle. The result and the error output both come from registers and appear one clock after the inputs are sampled. A master enable at 0, or both group enables at 0, gives a zero result and no error. Arithmetic wraps at the operand width.

Top module: `alu_dual_enable`

## Requirements
- R1: When `alu_en` is 0 at a rising clock edge, `result` is 0 and `err` is 0 after that edge, whatever the other inputs are.
- R2: When `alu_en` is 1 and both `grp_a_en` and `grp_b_en` are 0, `result` is 0 and `err` is 0 after the edge.
- R3: With `grp_a_en`=1 and `grp_b_en`=0, `op_a` selects an operation: 0 gives A+B, 1 gives A-B, 2 gives A XOR B, 3 gives A AND B, 4 gives A OR B, 5 gives A XNOR B and 6 gives A NAND B.
- R4: With `grp_a_en`=1 and `grp_b_en`=0, `op_a`=7 is reserved: `err` is 1 and `result` is 0.
- R5: With `grp_a_en`=0 and `grp_b_en`=1, `op_b` selects an operation: 0 gives A NAND B, 1 gives A+B and 2 gives A-B.
- R6: With `grp_a_en`=0 and `grp_b_en`=1, `op_b`=3 is reserved: `err` is 1 and `result` is 0.
- R7: With both group enables at 1, `op_b` selects an operation: 0 gives A XOR B, 1 gives A XNOR B, 2 gives A-1 and 3 gives B+2. `err` is never 1 in this mode.
- R8: `result` and `err` change only at a rising clock edge. They reflect the inputs sampled at that edge, so `err` is high for exactly as many cycles as a reserved code is sampled.
- R9: While `rst_n` is 0, `result` and `err` are 0 and the inputs have no effect.
- R10: Every arithmetic result wraps modulo 2^W. For example, with W=8: 200+100=44, 5-10=251, 0-1=255 and 255+2=1.
- R11: In a mode that uses only one opcode, the other opcode has no effect on `result` or `err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously by the system |
| alu_en | input | 1 | Master enable |
| grp_a_en | input | 1 | Group enable for the first table |
| grp_b_en | input | 1 | Group enable for the second table |
| op_a | input | 3 | Opcode for the first-group-only mode |
| op_b | input | 2 | Opcode for the modes that use the second group |
| opnd_a | input | W | Operand A |
| opnd_b | input | W | Operand B |
| result | output | W | Registered result |
| err | output | 1 | Registered reserved-opcode flag |

## Verification
The only state is the result and error registers, so a fault shows at the ports on the first edge after the input that triggers it. A wrong mode decode gives the wrong table entry or a spurious error one cycle later. A stuck error bit, or a missed clock enable, shows as `err` or `result` failing to drop on the next edge. The directed sequences therefore follow every reserved code with a legal one, and follow every nonzero result with a disabled cycle.

// File: rtl/alu_pkg.sv
`timescale 1ns/1ps
package alu_pkg;

  localparam int unsigned OPA_W = 3;
  localparam int unsigned OPB_W = 2;

  typedef enum logic [1:0] {
    MODE_OFF = 2'd0,
    MODE_A   = 2'd1,
    MODE_B   = 2'd2,
    MODE_AB  = 2'd3
  } alu_mode_e;

  typedef enum logic [OPA_W-1:0] {
    TA_ADD  = 3'd0,
    TA_SUB  = 3'd1,
    TA_XOR  = 3'd2,
    TA_AND  = 3'd3,
    TA_OR   = 3'd4,
    TA_XNOR = 3'd5,
    TA_NAND = 3'd6,
    TA_RSVD = 3'd7
  } tbl_a_op_e;

  typedef enum logic [OPB_W-1:0] {
    TB_NAND = 2'd0,
    TB_ADD  = 2'd1,
    TB_SUB  = 2'd2,
    TB_RSVD = 2'd3
  } tbl_b_op_e;

  typedef enum logic [OPB_W-1:0] {
    TD_XOR   = 2'd0,
    TD_XNOR  = 2'd1,
    TD_DECA  = 2'd2,
    TD_INCB2 = 2'd3
  } tbl_d_op_e;

endpackage

// File: rtl/alu_mode_dec.sv
`timescale 1ns/1ps
module alu_mode_dec
  import alu_pkg::*;
(
  input  logic      alu_en,
  input  logic      grp_a_en,
  input  logic      grp_b_en,
  output alu_mode_e mode
);

  always_comb begin
    if (!alu_en) begin
      mode = MODE_OFF;
    end else begin
      unique case ({grp_b_en, grp_a_en})
        2'b01:   mode = MODE_A;
        2'b10:   mode = MODE_B;
        2'b11:   mode = MODE_AB;
        default: mode = MODE_OFF;
      endcase
    end
  end

endmodule

// File: rtl/alu_table_a.sv
`timescale 1ns/1ps
module alu_table_a
  import alu_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic [OPA_W-1:0] op,
  input  logic [W-1:0]     a,
  input  logic [W-1:0]     b,
  output logic [W-1:0]     y,
  output logic             bad
);

  always_comb begin
    bad = 1'b0;
    unique case (op)
      TA_ADD:  y = a + b;
      TA_SUB:  y = a - b;
      TA_XOR:  y = a ^ b;
      TA_AND:  y = a & b;
      TA_OR:   y = a | b;
      TA_XNOR: y = ~(a ^ b);
      TA_NAND: y = ~(a & b);
      default: begin
        y   = '0;
        bad = 1'b1;
      end
    endcase
  end

endmodule

// File: rtl/alu_table_b.sv
`timescale 1ns/1ps
module alu_table_b
  import alu_pkg::*;
#(
  parameter int unsigned W    = 8,
  parameter bit          DUAL = 1'b0
) (
  input  logic [OPB_W-1:0] op,
  input  logic [W-1:0]     a,
  input  logic [W-1:0]     b,
  output logic [W-1:0]     y,
  output logic             bad
);

  localparam logic [W-1:0] STEP_DEC = W'(1);
  localparam logic [W-1:0] STEP_INC = W'(2);

  generate
    if (DUAL) begin : g_dual
      always_comb begin
        bad = 1'b0;
        unique case (op)
          TD_XOR:   y = a ^ b;
          TD_XNOR:  y = ~(a ^ b);
          TD_DECA:  y = a - STEP_DEC;
          default:  y = b + STEP_INC;
        endcase
      end
    end else begin : g_single
      always_comb begin
        bad = 1'b0;
        unique case (op)
          TB_NAND: y = ~(a & b);
          TB_ADD:  y = a + b;
          TB_SUB:  y = a - b;
          default: begin
            y   = '0;
            bad = 1'b1;
          end
        endcase
      end
    end
  endgenerate

endmodule

// File: rtl/alu_out_reg.sv
`timescale 1ns/1ps
module alu_out_reg #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] nxt_res,
  input  logic         nxt_err,
  output logic [W-1:0] res_q,
  output logic         err_q
);

  logic ld_en;

  assign ld_en = (nxt_res != res_q) || (nxt_err != err_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q <= '0;
      err_q <= 1'b0;
    end else if (ld_en) begin
      res_q <= nxt_res;
      err_q <= nxt_err;
    end
  end

endmodule

// File: rtl/alu_dual_enable.sv
`timescale 1ns/1ps
module alu_dual_enable
  import alu_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             alu_en,
  input  logic             grp_a_en,
  input  logic             grp_b_en,
  input  logic [OPA_W-1:0] op_a,
  input  logic [OPB_W-1:0] op_b,
  input  logic [W-1:0]     opnd_a,
  input  logic [W-1:0]     opnd_b,
  output logic [W-1:0]     result,
  output logic             err
);

  alu_mode_e    mode;
  logic [W-1:0] ya, yb, yd, nxt_res;
  logic         bad_a, bad_b, bad_d, nxt_err;

  alu_mode_dec u_dec (
    .alu_en   (alu_en),
    .grp_a_en (grp_a_en),
    .grp_b_en (grp_b_en),
    .mode     (mode)
  );

  alu_table_a #(.W(W)) u_tbl_a (
    .op  (op_a),
    .a   (opnd_a),
    .b   (opnd_b),
    .y   (ya),
    .bad (bad_a)
  );

  alu_table_b #(.W(W), .DUAL(1'b0)) u_tbl_b (
    .op  (op_b),
    .a   (opnd_a),
    .b   (opnd_b),
    .y   (yb),
    .bad (bad_b)
  );

  alu_table_b #(.W(W), .DUAL(1'b1)) u_tbl_d (
    .op  (op_b),
    .a   (opnd_a),
    .b   (opnd_b),
    .y   (yd),
    .bad (bad_d)
  );

  always_comb begin
    unique case (mode)
      MODE_A: begin
        nxt_res = ya;
        nxt_err = bad_a;
      end
      MODE_B: begin
        nxt_res = yb;
        nxt_err = bad_b;
      end
      MODE_AB: begin
        nxt_res = yd;
        nxt_err = bad_d;
      end
      default: begin
        nxt_res = '0;
        nxt_err = 1'b0;
      end
    endcase
  end

  alu_out_reg #(.W(W)) u_oreg (
    .clk     (clk),
    .rst_n   (rst_n),
    .nxt_res (nxt_res),
    .nxt_err (nxt_err),
    .res_q   (result),
    .err_q   (err)
  );

endmodule

// File: rtl/alu_dual_enable_chk.sv
`timescale 1ns/1ps
module alu_dual_enable_chk #(
  parameter int unsigned W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         alu_en,
  input logic         grp_a_en,
  input logic         grp_b_en,
  input logic [2:0]   op_a,
  input logic [1:0]   op_b,
  input logic [W-1:0] opnd_a,
  input logic [W-1:0] opnd_b,
  input logic [W-1:0] result,
  input logic         err
);

  a_r1_off_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !alu_en |=> (result == '0) && !err);

  a_r2_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    alu_en && !grp_a_en && !grp_b_en |=> (result == '0) && !err);

  a_r3_add_a: assert property (@(posedge clk) disable iff (!rst_n)
    alu_en && grp_a_en && !grp_b_en && (op_a == 3'd0)
      |=> !err && (result == W'($past(opnd_a) + $past(opnd_b))));

  a_r4_rsvd_a: assert property (@(posedge clk) disable iff (!rst_n)
    alu_en && grp_a_en && !grp_b_en && (op_a == 3'd7) |=> err && (result == '0));

  a_r6_rsvd_b: assert property (@(posedge clk) disable iff (!rst_n)
    alu_en && !grp_a_en && grp_b_en && (op_b == 2'd3) |=> err && (result == '0));

  a_r7_dual_no_err: assert property (@(posedge clk) disable iff (!rst_n)
    alu_en && grp_a_en && grp_b_en |=> !err);

  a_r8_err_one_shot: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (result == '0));

  a_r9_reset_clear: assert property (@(posedge clk)
    !rst_n |-> (result == '0) && !err);

endmodule

bind alu_dual_enable alu_dual_enable_chk #(.W(W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .alu_en   (alu_en),
  .grp_a_en (grp_a_en),
  .grp_b_en (grp_b_en),
  .op_a     (op_a),
  .op_b     (op_b),
  .opnd_a   (opnd_a),
  .opnd_b   (opnd_b),
  .result   (result),
  .err      (err)
);

// File: tb/tb_alu_dual_enable.sv
`timescale 1ns/1ps
module tb_alu_dual_enable;

  localparam int unsigned W = 8;

  logic         clk;
  logic         rst_n;
  logic         alu_en, grp_a_en, grp_b_en;
  logic [2:0]   op_a;
  logic [1:0]   op_b;
  logic [W-1:0] opnd_a, opnd_b;
  logic [W-1:0] result;
  logic         err;

  int total = 0;
  int bad   = 0;

  alu_dual_enable #(.W(W)) dut (
    .clk(clk), .rst_n(rst_n), .alu_en(alu_en), .grp_a_en(grp_a_en),
    .grp_b_en(grp_b_en), .op_a(op_a), .op_b(op_b), .opnd_a(opnd_a),
    .opnd_b(opnd_b), .result(result), .err(err)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic logic [W:0] model(input logic en, input logic ae, input logic be,
                                       input logic [2:0] oa, input logic [1:0] ob,
                                       input logic [W-1:0] a, input logic [W-1:0] b);
    logic [W-1:0] y;
    logic         e;
    y = '0;
    e = 1'b0;
    if (en && ae && !be) begin
      case (oa)
        3'd0: y = a + b;
        3'd1: y = a - b;
        3'd2: y = a ^ b;
        3'd3: y = a & b;
        3'd4: y = a | b;
        3'd5: y = ~(a ^ b);
        3'd6: y = ~(a & b);
        default: e = 1'b1;
      endcase
    end else if (en && !ae && be) begin
      case (ob)
        2'd0: y = ~(a & b);
        2'd1: y = a + b;
        2'd2: y = a - b;
        default: e = 1'b1;
      endcase
    end else if (en && ae && be) begin
      case (ob)
        2'd0: y = a ^ b;
        2'd1: y = ~(a ^ b);
        2'd2: y = a - 8'd1;
        default: y = b + 8'd2;
      endcase
    end
    return {e, y};
  endfunction

  task automatic chk(input string tag, input logic [W-1:0] exp_r, input logic exp_e);
    total++;
    if (result !== exp_r || err !== exp_e) begin
      bad++;
      $display("FAIL %s: actual result=%0d err=%0b expected result=%0d err=%0b",
               tag, result, err, exp_r, exp_e);
    end
  endtask

  task automatic drive(input logic en, input logic ae, input logic be,
                       input logic [2:0] oa, input logic [1:0] ob,
                       input logic [W-1:0] a, input logic [W-1:0] b);
    alu_en = en; grp_a_en = ae; grp_b_en = be;
    op_a = oa; op_b = ob; opnd_a = a; opnd_b = b;
  endtask

  task automatic step(input string tag, input logic en, input logic ae, input logic be,
                      input logic [2:0] oa, input logic [1:0] ob,
                      input logic [W-1:0] a, input logic [W-1:0] b);
    logic [W:0] m;
    @(negedge clk);
    drive(en, ae, be, oa, ob, a, b);
    m = model(en, ae, be, oa, ob, a, b);
    @(negedge clk);
    chk(tag, m[W-1:0], m[W]);
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    drive(1'b1, 1'b1, 1'b0, 3'd0, 2'd0, 8'd9, 8'd7);
    repeat (3) @(negedge clk);
    chk("R9 reset holds zero", 8'd0, 1'b0);
    drive(1'b1, 1'b1, 1'b0, 3'd7, 2'd0, 8'd9, 8'd7);
    @(negedge clk);
    chk("R9 reserved code ignored in reset", 8'd0, 1'b0);
    rst_n = 1'b1;
  endtask

  task automatic t_disable;
    step("R3 setup add", 1, 1, 0, 3'd0, 2'd0, 8'd20, 8'd22);
    step("R1 alu_en low clears", 0, 1, 0, 3'd0, 2'd0, 8'd20, 8'd22);
    step("R4 setup reserved", 1, 1, 0, 3'd7, 2'd0, 8'd1, 8'd1);
    step("R1 alu_en low clears err", 0, 1, 1, 3'd7, 2'd3, 8'd1, 8'd1);
    step("R3 setup or", 1, 1, 0, 3'd4, 2'd0, 8'h0f, 8'hf0);
    step("R2 both groups low clears", 1, 0, 0, 3'd4, 2'd3, 8'h0f, 8'hf0);
  endtask

  task automatic t_table_a;
    for (int k = 0; k < 7; k++) begin
      step("R3 table A pattern1", 1, 1, 0, 3'(k), 2'd0, 8'hc5, 8'h3a);
      step("R3 table A pattern2", 1, 1, 0, 3'(k), 2'd0, 8'h12, 8'hff);
    end
    step("R10 add wraps", 1, 1, 0, 3'd0, 2'd0, 8'd200, 8'd100);
    chk("R10 200+100", 8'd44, 1'b0);
    step("R10 sub wraps", 1, 1, 0, 3'd1, 2'd0, 8'd5, 8'd10);
    chk("R10 5-10", 8'd251, 1'b0);
  endtask

  task automatic t_rsvd;
    step("R4 op_a reserved", 1, 1, 0, 3'd7, 2'd1, 8'hff, 8'hff);
    chk("R4 op_a reserved explicit", 8'd0, 1'b1);
    step("R4 reserved held two cycles", 1, 1, 0, 3'd7, 2'd1, 8'h10, 8'h01);
    step("R8 err drops after legal code", 1, 1, 0, 3'd2, 2'd0, 8'h55, 8'h0f);
    chk("R8 err drops explicit", 8'h5a, 1'b0);
    step("R6 op_b reserved", 1, 0, 1, 3'd0, 2'd3, 8'h33, 8'h44);
    chk("R6 op_b reserved explicit", 8'd0, 1'b1);
    step("R6 err drops after legal code", 1, 0, 1, 3'd0, 2'd1, 8'h33, 8'h44);
  endtask

  task automatic t_table_b;
    for (int k = 0; k < 3; k++) begin
      step("R5 table B pattern1", 1, 0, 1, 3'd0, 2'(k), 8'hc5, 8'h3a);
      step("R5 table B pattern2", 1, 0, 1, 3'd5, 2'(k), 8'h01, 8'h80);
    end
  endtask

  task automatic t_dual;
    for (int k = 0; k < 4; k++) begin
      step("R7 dual table pattern1", 1, 1, 1, 3'd7, 2'(k), 8'ha5, 8'h0f);
      step("R7 dual table pattern2", 1, 1, 1, 3'd0, 2'(k), 8'h70, 8'h81);
    end
    step("R10 decrement wraps", 1, 1, 1, 3'd7, 2'd2, 8'd0, 8'd0);
    chk("R10 0-1", 8'd255, 1'b0);
    step("R10 increment wraps", 1, 1, 1, 3'd7, 2'd3, 8'd0, 8'd255);
    chk("R10 255+2", 8'd1, 1'b0);
  endtask

  task automatic t_ignore;
    step("R11 ref mode A", 1, 1, 0, 3'd3, 2'd0, 8'hf3, 8'h3c);
    step("R11 mode A op_b=3 ignored", 1, 1, 0, 3'd3, 2'd3, 8'hf3, 8'h3c);
    chk("R11 mode A explicit", 8'h30, 1'b0);
    step("R11 mode B op_a=7 ignored", 1, 0, 1, 3'd7, 2'd2, 8'd50, 8'd8);
    chk("R11 mode B explicit", 8'd42, 1'b0);
  endtask

  task automatic t_latency;
    step("R8 prior value", 1, 1, 0, 3'd0, 2'd0, 8'd1, 8'd2);
    @(negedge clk);
    drive(1, 1, 0, 3'd0, 2'd0, 8'd10, 8'd20);
    #1.5;
    chk("R8 no change before edge", 8'd3, 1'b0);
    @(negedge clk);
    chk("R8 new value after one edge", 8'd30, 1'b0);
  endtask

  initial begin
    #1000000;
    bad++;
    total++;
    $display("FAIL R8 watchdog: actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    drive(0, 0, 0, 3'd0, 2'd0, 8'd0, 8'd0);
    t_reset();
    t_disable();
    t_table_a();
    t_rsvd();
    t_table_b();
    t_dual();
    t_ignore();
    t_latency();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule